// File: doc/BRIEF.md
# Register-Window Trap Entry Sequencer

This block carries out the architectural state change that happens when a processor with rotating register windows takes a trap. A trap request arrives on a valid/ready channel with an 8-bit trap type. The block holds the trap-related state itself: the trap-enable bit, the supervisor bit, the saved supervisor bit, the current window pointer and the trap base register. It takes the current program counter and next program counter from the fetch path. On acceptance it commits every update on a single clock edge. In the following cycle it pulses the register-file writes, the fetch redirect and, for external interrupts, an acknowledge.

The rest of the pipeline loads the state through a plain write port, which covers the return-from-trap path and writes to the status register. A request that arrives while traps are disabled is not vectored. The block either raises a sticky shutdown flag, for a software trap of type 0x80 when shutdown is enabled, or enters a sticky error state. Both conditions hold until reset.

The request channel uses back-pressure: `req_ready` is low only while the block is halted in error or shutdown. A request held with `req_valid` high is taken on the first edge where `req_ready` is high. The register-file write, redirect and acknowledge outputs are single-cycle pulses with no ready, so their consumers must take them in that cycle.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the outputs are as follows: error and shutdown flags are 0, the supervisor bit is 1, the saved supervisor bit and trap-enable bit are 0, the window pointer is 0, the trap base register is 0, and no pulse output is active.
- R2: `req_ready` is 1 whenever the block is neither in error state nor shut down. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1, and all its state updates are visible right after that edge.
- R3: On an accepted request with trap-enable 1, the trap-enable bit becomes 0, the saved supervisor bit takes the old supervisor bit, and the supervisor bit becomes 1.
- R4: On such a trap the window pointer becomes the old pointer minus one, wrapping from 0 to NWIN-1.
- R5: For one cycle after such a trap, `rf_wr_en` is 1 and `rf_wr_win` is the new window. Port 0 writes the old PC to window-relative index 9, and port 1 writes the old nPC to index 10.
- R6: The trap base register keeps bits 31:12, takes the trap type in bits 11:4, and has bits 3:0 equal to 0. For one cycle after the trap, `redir_valid` is 1 with `redir_pc` equal to that register and `redir_npc` equal to it plus 4.
- R7: `ack_valid` pulses for one cycle after a trap that was actually vectored, and only when bits 7:4 of the trap type equal 1. It carries the trap type on `ack_tt`.
- R8: An accepted request with trap-enable 0 that does not meet R9 sets the error flag. No vector, register write or acknowledge is produced, and the trap-enable bit, supervisor bits, window pointer and trap base register keep their values.
- R9: An accepted request with trap-enable 0, trap type 0x80 and `shutdown_en` 1 sets the shutdown flag instead of the error flag, again with no vector, write or acknowledge.
- R10: While the error or shutdown flag is set, requests and state writes are ignored and the flags stay set until reset.
- R11: The state write port loads the trap-enable bit, both supervisor bits, the window pointer and the base field on an edge where no request is accepted. When a request is accepted on the same edge, the trap update wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Trap request present |
| req_ready | output | 1 | Request can be taken |
| req_tt | input | 8 | Trap type |
| cur_pc | input | XLEN | Current PC from fetch |
| cur_npc | input | XLEN | Current next PC from fetch |
| shutdown_en | input | 1 | Type 0x80 with traps disabled requests shutdown |
| st_wr_en | input | 1 | Load state from write port |
| st_wr_et | input | 1 | Trap-enable value to load |
| st_wr_s | input | 1 | Supervisor value to load |
| st_wr_ps | input | 1 | Saved supervisor value to load |
| st_wr_cwp | input | CW | Window pointer to load |
| st_wr_tba | input | XLEN-12 | Trap base field to load |
| et_o | output | 1 | Trap-enable bit |
| s_o | output | 1 | Supervisor bit |
| ps_o | output | 1 | Saved supervisor bit |
| cwp_o | output | CW | Current window pointer |
| tbr_o | output | XLEN | Trap base register |
| rf_wr_en | output | 1 | Register-file write pulse (both ports) |
| rf_wr_win | output | CW | Window written |
| rf_wr0_idx | output | 5 | Port 0 window-relative index (9) |
| rf_wr0_data | output | XLEN | Saved PC |
| rf_wr1_idx | output | 5 | Port 1 window-relative index (10) |
| rf_wr1_data | output | XLEN | Saved nPC |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | XLEN | Redirect PC |
| redir_npc | output | XLEN | Redirect next PC |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_tt | output | 8 | Acknowledged trap type |
| err_state | output | 1 | Sticky error state |
| shutdown | output | 1 | Sticky shutdown request |

## Verification
Two functions can fall on the same edge: a trap acceptance and a load through the state write port. The bench provokes this by driving `st_wr_en` with different values in the same cycle as an accepted request. It then judges the outcome by the window pointer, base field and mode bits, which must match the trap update and not the written values. A second collision is a request and a write while the block is halted. There the bench checks that neither one moves any state output.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int TT_W = 8;
  localparam int VEC_SHIFT = 4;
  localparam logic [3:0] EXT_IRQ_GROUP = 4'h1;
  localparam logic [TT_W-1:0] HALT_TT = 8'h80;
  localparam logic [4:0] SAVE_PC_IDX = 5'd9;
  localparam logic [4:0] SAVE_NPC_IDX = 5'd10;

  typedef enum logic [1:0] {
    OUT_VECTOR = 2'd0,
    OUT_ERROR  = 2'd1,
    OUT_HALT   = 2'd2
  } trap_outcome_e;
endpackage

// File: rtl/trap_classifier.sv
module trap_classifier
  import trap_pkg::*;
(
  input  logic [TT_W-1:0] tt,
  input  logic            et,
  input  logic            shutdown_en,
  output trap_outcome_e   outcome,
  output logic            is_ext_irq
);
  always_comb begin
    if (et)
      outcome = OUT_VECTOR;
    else if (tt == HALT_TT && shutdown_en)
      outcome = OUT_HALT;
    else
      outcome = OUT_ERROR;
  end

  assign is_ext_irq = (tt[TT_W-1:VEC_SHIFT] == EXT_IRQ_GROUP);
endmodule

// File: rtl/cwp_rotator.sv
module cwp_rotator #(
  parameter int NWIN = 8,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [CW-1:0] cwp_in,
  output logic [CW-1:0] cwp_dec
);
  localparam bit IS_POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (IS_POW2) begin : g_pow2
      assign cwp_dec = cwp_in - CW'(1);
    end else begin : g_wrap
      assign cwp_dec = (cwp_in == '0) ? CW'(NWIN - 1) : cwp_in - CW'(1);
    end
  endgenerate
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int TBA_W = XLEN - TT_W - VEC_SHIFT
) (
  input  logic [TBA_W-1:0] tba,
  input  logic [TT_W-1:0]  tt,
  output logic [XLEN-1:0]  tbr,
  output logic [XLEN-1:0]  vec_npc
);
  assign tbr     = {tba, tt, {VEC_SHIFT{1'b0}}};
  assign vec_npc = tbr + XLEN'(4);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int TBA_W = XLEN - TT_W - VEC_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TT_W-1:0]  req_tt,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_npc,
  input  logic             shutdown_en,
  input  logic             st_wr_en,
  input  logic             st_wr_et,
  input  logic             st_wr_s,
  input  logic             st_wr_ps,
  input  logic [CW-1:0]    st_wr_cwp,
  input  logic [TBA_W-1:0] st_wr_tba,
  output logic             et_o,
  output logic             s_o,
  output logic             ps_o,
  output logic [CW-1:0]    cwp_o,
  output logic [XLEN-1:0]  tbr_o,
  output logic             rf_wr_en,
  output logic [CW-1:0]    rf_wr_win,
  output logic [4:0]       rf_wr0_idx,
  output logic [XLEN-1:0]  rf_wr0_data,
  output logic [4:0]       rf_wr1_idx,
  output logic [XLEN-1:0]  rf_wr1_data,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc,
  output logic [XLEN-1:0]  redir_npc,
  output logic             ack_valid,
  output logic [TT_W-1:0]  ack_tt,
  output logic             err_state,
  output logic             shutdown
);
  logic             et_q, s_q, ps_q, err_q, halt_q;
  logic [CW-1:0]    cwp_q, cwp_next;
  logic [TBA_W-1:0] tba_q;
  logic [TT_W-1:0]  tt_q;
  logic             we_q, redir_q, ack_q;
  logic [XLEN-1:0]  save_pc_q, save_npc_q;
  logic [TT_W-1:0]  ack_tt_q;

  trap_outcome_e outcome;
  logic          is_ext_irq;
  logic          stopped, accept, do_vector, do_write;

  trap_classifier u_class (
    .tt          (req_tt),
    .et          (et_q),
    .shutdown_en (shutdown_en),
    .outcome     (outcome),
    .is_ext_irq  (is_ext_irq)
  );

  cwp_rotator #(.NWIN(NWIN)) u_rot (
    .cwp_in  (cwp_q),
    .cwp_dec (cwp_next)
  );

  trap_vector_gen #(.XLEN(XLEN)) u_vec (
    .tba     (tba_q),
    .tt      (tt_q),
    .tbr     (tbr_o),
    .vec_npc (redir_npc)
  );

  assign stopped   = err_q | halt_q;
  assign req_ready = ~stopped;
  assign accept    = req_valid & ~stopped;
  assign do_vector = accept & (outcome == OUT_VECTOR);
  assign do_write  = st_wr_en & ~stopped & ~accept;

  // architectural state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      et_q   <= 1'b0;
      s_q    <= 1'b1;
      ps_q   <= 1'b0;
      cwp_q  <= '0;
      tba_q  <= '0;
      tt_q   <= '0;
      err_q  <= 1'b0;
      halt_q <= 1'b0;
    end else if (accept) begin
      unique case (outcome)
        OUT_VECTOR: begin
          et_q  <= 1'b0;
          ps_q  <= s_q;
          s_q   <= 1'b1;
          cwp_q <= cwp_next;
          tt_q  <= req_tt;
        end
        OUT_HALT:  halt_q <= 1'b1;
        default:   err_q  <= 1'b1;
      endcase
    end else if (do_write) begin
      et_q  <= st_wr_et;
      s_q   <= st_wr_s;
      ps_q  <= st_wr_ps;
      cwp_q <= st_wr_cwp;
      tba_q <= st_wr_tba;
    end
  end

  // single-cycle side effects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q       <= 1'b0;
      redir_q    <= 1'b0;
      ack_q      <= 1'b0;
      save_pc_q  <= '0;
      save_npc_q <= '0;
      ack_tt_q   <= '0;
    end else begin
      we_q    <= do_vector;
      redir_q <= do_vector;
      ack_q   <= do_vector & is_ext_irq;
      if (do_vector) begin
        save_pc_q  <= cur_pc;
        save_npc_q <= cur_npc;
        ack_tt_q   <= req_tt;
      end
    end
  end

  assign et_o        = et_q;
  assign s_o         = s_q;
  assign ps_o        = ps_q;
  assign cwp_o       = cwp_q;
  assign rf_wr_en    = we_q;
  assign rf_wr_win   = cwp_q;
  assign rf_wr0_idx  = SAVE_PC_IDX;
  assign rf_wr0_data = save_pc_q;
  assign rf_wr1_idx  = SAVE_NPC_IDX;
  assign rf_wr1_data = save_npc_q;
  assign redir_valid = redir_q;
  assign redir_pc    = tbr_o;
  assign ack_valid   = ack_q;
  assign ack_tt      = ack_tt_q;
  assign err_state   = err_q;
  assign shutdown    = halt_q;
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [7:0]      req_tt,
  input logic            shutdown_en,
  input logic            et_o,
  input logic            s_o,
  input logic [CW-1:0]   cwp_o,
  input logic [XLEN-1:0] tbr_o,
  input logic            rf_wr_en,
  input logic [CW-1:0]   rf_wr_win,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic [XLEN-1:0] redir_npc,
  input logic            ack_valid,
  input logic [7:0]      ack_tt,
  input logic            err_state,
  input logic            shutdown
);
  logic take;
  assign take = req_valid && req_ready;

  a_r3_mode_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && et_o) |=> (!et_o && s_o));

  a_r4_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && et_o) |=> (cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - CW'(1))));

  a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_wr_win == cwp_o && redir_valid));

  a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_pc == tbr_o && redir_npc == redir_pc + XLEN'(4) && tbr_o[3:0] == 4'h0));

  a_r7_ack_group: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_tt[7:4] == 4'h1 && redir_valid));

  a_r8_error_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !et_o && !(req_tt == 8'h80 && shutdown_en)) |=> (err_state && !redir_valid && !rf_wr_en));

  a_r9_halt_request: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !et_o && req_tt == 8'h80 && shutdown_en) |=> (shutdown && !err_state && !redir_valid));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_state || shutdown) |=> ((err_state || shutdown) && !req_ready && $stable(cwp_o) && $stable(tbr_o)));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_tt(req_tt), .shutdown_en(shutdown_en), .et_o(et_o), .s_o(s_o),
  .cwp_o(cwp_o), .tbr_o(tbr_o), .rf_wr_en(rf_wr_en), .rf_wr_win(rf_wr_win),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
  .ack_valid(ack_valid), .ack_tt(ack_tt), .err_state(err_state), .shutdown(shutdown)
);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int CW = $clog2(NWIN);
  localparam int TBA_W = XLEN - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_tt = '0;
  logic [XLEN-1:0] cur_pc = '0, cur_npc = '0;
  logic shutdown_en = 1'b0;
  logic st_wr_en = 1'b0, st_wr_et = 1'b0, st_wr_s = 1'b0, st_wr_ps = 1'b0;
  logic [CW-1:0] st_wr_cwp = '0;
  logic [TBA_W-1:0] st_wr_tba = '0;
  logic et_o, s_o, ps_o;
  logic [CW-1:0] cwp_o, rf_wr_win;
  logic [XLEN-1:0] tbr_o, rf_wr0_data, rf_wr1_data, redir_pc, redir_npc;
  logic [4:0] rf_wr0_idx, rf_wr1_idx;
  logic rf_wr_en, redir_valid, ack_valid, err_state, shutdown;
  logic [7:0] ack_tt;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  logic m_et, m_s, m_ps, m_err, m_halt;
  int m_cwp;
  logic [TBA_W-1:0] m_tba;
  logic [7:0] m_tt;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN)) u_trap_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tt(req_tt), .cur_pc(cur_pc), .cur_npc(cur_npc), .shutdown_en(shutdown_en),
    .st_wr_en(st_wr_en), .st_wr_et(st_wr_et), .st_wr_s(st_wr_s), .st_wr_ps(st_wr_ps),
    .st_wr_cwp(st_wr_cwp), .st_wr_tba(st_wr_tba), .et_o(et_o), .s_o(s_o), .ps_o(ps_o),
    .cwp_o(cwp_o), .tbr_o(tbr_o), .rf_wr_en(rf_wr_en), .rf_wr_win(rf_wr_win),
    .rf_wr0_idx(rf_wr0_idx), .rf_wr0_data(rf_wr0_data), .rf_wr1_idx(rf_wr1_idx),
    .rf_wr1_data(rf_wr1_data), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .redir_npc(redir_npc), .ack_valid(ack_valid), .ack_tt(ack_tt),
    .err_state(err_state), .shutdown(shutdown)
  );

  function automatic int dec_win(int c);
    return (c == 0) ? NWIN - 1 : c - 1;
  endfunction

  function automatic logic [XLEN-1:0] exp_tbr();
    return {m_tba, m_tt, 4'h0};
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " et"}, XLEN'(et_o), XLEN'(m_et));
    chk({req, " s"}, XLEN'(s_o), XLEN'(m_s));
    chk({req, " ps"}, XLEN'(ps_o), XLEN'(m_ps));
    chk({req, " cwp"}, XLEN'(cwp_o), XLEN'(m_cwp));
    chk({req, " tbr"}, tbr_o, exp_tbr());
    chk({req, " err"}, XLEN'(err_state), XLEN'(m_err));
    chk({req, " shutdown"}, XLEN'(shutdown), XLEN'(m_halt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_et = 0; m_s = 1; m_ps = 0; m_cwp = 0; m_tba = '0; m_tt = '0;
    m_err = 0; m_halt = 0;
    chk_state("R1 reset");
    chk("R1 no pulse", XLEN'({rf_wr_en, redir_valid, ack_valid}), '0);
    chk("R2 ready after reset", XLEN'(req_ready), 1);
  endtask

  task automatic do_write(logic et, logic s, logic ps, int cwp, logic [TBA_W-1:0] tba);
    @(negedge clk);
    st_wr_en = 1; st_wr_et = et; st_wr_s = s; st_wr_ps = ps;
    st_wr_cwp = CW'(cwp); st_wr_tba = tba;
    @(negedge clk);
    st_wr_en = 0;
    if (!(m_err || m_halt)) begin
      m_et = et; m_s = s; m_ps = ps; m_cwp = cwp; m_tba = tba;
    end
    chk_state("R11/R10 write");
  endtask

  task automatic do_trap(logic [7:0] tt, logic [XLEN-1:0] pc, logic [XLEN-1:0] npc,
                         logic shen, logic collide);
    logic acc, vec;
    @(negedge clk);
    req_valid = 1; req_tt = tt; cur_pc = pc; cur_npc = npc; shutdown_en = shen;
    if (collide) begin
      st_wr_en = 1; st_wr_et = ~m_et; st_wr_s = 0; st_wr_ps = ~m_s;
      st_wr_cwp = CW'(NWIN / 2); st_wr_tba = ~m_tba;
    end
    #1;
    acc = !(m_err || m_halt);
    chk("R2 ready", XLEN'(req_ready), XLEN'(acc));
    vec = acc && m_et;
    @(negedge clk);
    req_valid = 0; st_wr_en = 0;
    if (vec) begin
      m_et = 0; m_ps = m_s; m_s = 1; m_cwp = dec_win(m_cwp); m_tt = tt;
    end else if (acc) begin
      if (tt == 8'h80 && shen) m_halt = 1;
      else m_err = 1;
    end
    chk_state(collide ? "R11 trap wins" : (vec ? "R3/R4 entry" : "R8/R9/R10 no vector"));
    chk("R5 write pulse", XLEN'(rf_wr_en), XLEN'(vec));
    chk("R6 redirect pulse", XLEN'(redir_valid), XLEN'(vec));
    chk("R7 ack pulse", XLEN'(ack_valid), XLEN'(vec && tt[7:4] == 4'h1));
    if (vec) begin
      chk("R5 window", XLEN'(rf_wr_win), XLEN'(m_cwp));
      chk("R5 idx9", XLEN'(rf_wr0_idx), 9);
      chk("R5 pc", rf_wr0_data, pc);
      chk("R5 idx10", XLEN'(rf_wr1_idx), 10);
      chk("R5 npc", rf_wr1_data, npc);
      chk("R6 pc", redir_pc, exp_tbr());
      chk("R6 npc", redir_npc, exp_tbr() + 4);
      if (tt[7:4] == 4'h1) chk("R7 tt", XLEN'(ack_tt), XLEN'(tt));
    end
    @(negedge clk);
    chk("R5 pulse ends", XLEN'({rf_wr_en, redir_valid, ack_valid}), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    do_reset();
    // R4 wrap from window 0 and back-to-back entries
    do_write(1, 0, 0, 0, 20'hABCDE);
    do_trap(8'h05, 32'h1000, 32'h1004, 0, 0);
    do_write(1, 0, 1, m_cwp, m_tba);
    do_trap(8'h1F, 32'h2000, 32'h2004, 0, 0);      // R7 level 15
    do_write(1, 1, 0, 3, 20'h00001);
    do_trap(8'h10, 32'h3000, 32'h3008, 0, 0);      // R7 group base
    do_write(1, 1, 0, 3, 20'h00001);
    do_trap(8'h20, 32'h3000, 32'h3008, 0, 0);      // R7 no ack
    do_write(1, 1, 0, 2, 20'hFFFFF);
    do_trap(8'h80, 32'h4000, 32'h4004, 1, 0);      // software trap, traps enabled
    // R11 collision
    do_write(1, 0, 0, 5, 20'h12345);
    do_trap(8'h11, 32'h5000, 32'h5004, 0, 1);
    // R9 shutdown, then R10 ignore
    do_write(0, 1, 0, 4, 20'h55555);
    do_trap(8'h80, 32'h6000, 32'h6004, 1, 0);
    do_trap(8'h01, 32'h6000, 32'h6004, 0, 0);
    do_write(1, 0, 0, 1, 20'h0F0F0);
    do_reset();
    // R8 error, then R10 ignore
    do_write(0, 1, 1, 6, 20'h33333);
    do_trap(8'h80, 32'h7000, 32'h7004, 0, 0);
    do_trap(8'h12, 32'h7000, 32'h7004, 0, 1);
    do_write(1, 0, 0, 1, 20'h0F0F0);
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic et = ($urandom_range(7) != 0);
      do_write(et, 1'($urandom), 1'($urandom), $urandom_range(NWIN - 1), TBA_W'($urandom));
      do_trap(8'($urandom), $urandom, $urandom, 1'($urandom), ($urandom_range(5) == 0));
      if (m_err || m_halt) do_reset();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule